// File: doc/BRIEF.md
# Pipeline Trap and Exception Controller

This block is the trap controller of a five-stage in-order pipeline. Each pipeline stage that can fault presents a request with a 5-bit exception code, the address of the faulting instruction and a flag that marks the instruction as sitting in a branch delay slot. Stages are indexed by age, so a higher index means an older instruction further down the pipe. The block also receives a 3-bit external interrupt code, with the resume address and slot flag that go with it, and a strobe for the return-from-trap instruction.

In the same cycle as an accepted trap, the block raises a flush and presents the fixed handler vector 0x00001000 as the new fetch address. At the next clock edge it records the trap in two read-only registers: a saved-PC register and a trap-cause register. It also holds a single privilege bit that selects user or system mode. Software reads the two registers through a combinational read port. A write port is present, but both registers ignore it.

Top module: `trap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is in user mode (`sys_mode`=0), the saved PC and the cause register both read 0, and `flush` is low.
- R2: An accepted trap drives `flush`=1 and `redirect_pc`=0x00001000 in the same cycle. From the next cycle on, `sys_mode`=1.
- R3: In system mode a nonzero `irq_code` is ignored: no flush, and both registers keep their values. A synchronous fault still flushes and redirects, and the block stays in system mode.
- R4: When several sources fault in the same cycle, the highest source index wins. An external interrupt is taken only in user mode and only when no synchronous fault is taken in that cycle.
- R5: Cause bits 6:2 hold the code. Interrupt = 0. Load/fetch address error = 4. Store address error = 5. Syscall = 8. Illegal instruction = 10. Overflow = 12. A synchronous source supplies its own code.
- R6: Cause bits 15:8 are a one-hot pending field. Interrupt code n (1..7) sets bit 8+n, so code 4 sets bit 12. The field is zero after a synchronous fault.
- R7: Cause bit 31 copies the delay-slot flag of the trapping instruction. All other cause bits read 0.
- R8: The saved PC is the trapping instruction's address, or that address minus 4 (the branch) when the instruction is in a delay slot. It changes only when a trap is taken.
- R9: `mfc_sel`=13 reads the cause register, 14 reads the saved PC, and any other value reads 0. A write (`mtc_valid`) has no effect on either register.
- R10: Return-from-trap (`rfe_valid`) in system mode returns to user mode when no older fault is taken. In user mode it traps with code 10, using the address and slot flag of source index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | NSRC | Per-source fault request (higher index is older) |
| src_code | input | NSRC*5 | Per-source exception code |
| src_pc | input | NSRC*AW | Per-source faulting instruction address |
| src_in_slot | input | NSRC | Per-source delay-slot flag |
| irq_code | input | 3 | External interrupt code, 0 means none |
| irq_pc | input | AW | Resume address recorded for an interrupt |
| irq_in_slot | input | 1 | Delay-slot flag for the interrupt resume address |
| rfe_valid | input | 1 | Return-from-trap issued by source RFE_SRC |
| mfc_sel | input | 5 | Register select for reads |
| mfc_data | output | 32 | Read data |
| mtc_valid | input | 1 | Write strobe (ignored by both registers) |
| mtc_sel | input | 5 | Write register select |
| mtc_data | input | 32 | Write data |
| flush | output | 1 | Trap accepted this cycle: flush the pipeline |
| redirect_pc | output | AW | Handler vector, valid while flush is high |
| sys_mode | output | 1 | 1 = system mode, 0 = user mode |

## Verification
The bench targets four corner cases:
- An interrupt that arrives in the same cycle as a synchronous fault. A design that lets the interrupt win would record code 0 and the wrong saved PC.
- A delay-slot trap. A design that saves the slot address instead of the branch address would resume past the branch.
- An interrupt in system mode. A design without masking would flush and overwrite the saved PC in the middle of the handler.
- Return-from-trap in both modes, and a collision of the oldest and youngest sources. Errors here show up as a wrong privilege bit or a cause code taken from the younger source.

Seeded random traffic then compares every cycle's flush, mode and read data against a bench model.

// File: rtl/trap_pkg.sv
// Shared constants and helpers for the trap controller.
// Assumes 5-bit exception codes and a 3-bit interrupt code.
package trap_pkg;
    localparam logic [4:0] CODE_IRQ      = 5'd0;
    localparam logic [4:0] CODE_ADDR_LD  = 5'd4;
    localparam logic [4:0] CODE_ADDR_ST  = 5'd5;
    localparam logic [4:0] CODE_SYSCALL  = 5'd8;
    localparam logic [4:0] CODE_ILLEGAL  = 5'd10;
    localparam logic [4:0] CODE_OVERFLOW = 5'd12;
    localparam logic [4:0] SEL_CAUSE     = 5'd13;
    localparam logic [4:0] SEL_EPC       = 5'd14;

    // Turn an interrupt code into its one-hot pending bit (code 0 gives none).
    function automatic logic [7:0] irq_onehot(input logic [2:0] c);
        logic [7:0] r;
        r = 8'd0;
        if (c != 3'd0) r[c] = 1'b1;
        return r;
    endfunction

    // Pack the cause word: slot flag, pending field, code field.
    function automatic logic [31:0] pack_cause(input logic slot, input logic [7:0] pend,
                                               input logic [4:0] code);
        return {slot, 15'd0, pend, 1'b0, code, 2'b00};
    endfunction
endpackage

// File: rtl/trap_prio.sv
// Picks the oldest faulting source (highest index wins).
// Assumes at most one return-from-trap at a time, issued by source RFE_SRC.
// A return-from-trap in user mode is turned into an illegal-instruction fault
// of that source unless the source already reports its own fault.
module trap_prio #(
    parameter int NSRC    = 4,
    parameter int AW      = 32,
    parameter int RFE_SRC = 1
) (
    input  logic [NSRC-1:0]    src_valid,
    input  logic [NSRC*5-1:0]  src_code,
    input  logic [NSRC*AW-1:0] src_pc,
    input  logic [NSRC-1:0]    src_in_slot,
    input  logic               rfe_fault,
    output logic               hit,
    output logic [4:0]         win_code,
    output logic [AW-1:0]      win_pc,
    output logic               win_slot
);
    import trap_pkg::*;

    logic [NSRC-1:0] eff_valid;
    logic [4:0]      eff_code [NSRC];

    // Per-source effective request, with the return-from-trap fault folded in.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == RFE_SRC) begin : g_rfe
            assign eff_valid[i] = src_valid[i] | rfe_fault;
            assign eff_code[i]  = src_valid[i] ? src_code[i*5 +: 5] : CODE_ILLEGAL;
        end else begin : g_plain
            assign eff_valid[i] = src_valid[i];
            assign eff_code[i]  = src_code[i*5 +: 5];
        end
    end

    // Scan from youngest to oldest so the last valid source (the oldest) wins.
    always_comb begin
        hit      = 1'b0;
        win_code = CODE_IRQ;
        win_pc   = '0;
        win_slot = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (eff_valid[i]) begin
                hit      = 1'b1;
                win_code = eff_code[i];
                win_pc   = src_pc[i*AW +: AW];
                win_slot = src_in_slot[i];
            end
        end
    end
endmodule

// File: rtl/trap_regs.sv
// Holds the privilege bit, the saved PC and the cause register.
// Assumes take and rfe_ok are never high together. Registers are read-only to
// software: the write strobe only feeds the assertion that guards this.
module trap_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [4:0]    code,
    input  logic [AW-1:0] pc,
    input  logic          slot,
    input  logic [7:0]    pend,
    input  logic          rfe_ok,
    input  logic          mtc_valid,
    input  logic [4:0]    mtc_sel,
    input  logic [31:0]   mtc_data,
    output logic          mode_q,
    output logic [AW-1:0] epc_q,
    output logic [31:0]   cause_q
);
    import trap_pkg::*;

    // Privilege bit: a trap enters system mode, an allowed return leaves it.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= 1'b0;
        else if (take)   mode_q <= 1'b1;
        else if (rfe_ok) mode_q <= 1'b0;
    end

    // Saved PC and cause are captured only when a trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            epc_q   <= slot ? pc - AW'(4) : pc;
            cause_q <= pack_cause(slot, pend, code);
        end
    end

    a_r2_enter_sys: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mode_q);
    a_r10_rfe_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_ok && !take) |=> !mode_q);
    a_r6_pend_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_q[15:8]));
    a_r8_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(epc_q));
    a_r9_mtc_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (mtc_valid && mtc_sel == SEL_CAUSE && mtc_data != cause_q && !take)
        |=> $stable(cause_q));
endmodule

// File: rtl/trap_ctrl.sv
// Top of the trap controller: arbitrates synchronous faults and external
// interrupts, flushes and redirects to the handler vector, and serves reads.
// Assumes no two consecutive branches, so at most one delay-slot flag matters.
module trap_ctrl #(
    parameter int          NSRC    = 4,
    parameter int          AW      = 32,
    parameter int          RFE_SRC = 1,
    parameter logic [31:0] VECTOR  = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_valid,
    input  logic [NSRC*5-1:0]  src_code,
    input  logic [NSRC*AW-1:0] src_pc,
    input  logic [NSRC-1:0]    src_in_slot,
    input  logic [2:0]         irq_code,
    input  logic [AW-1:0]      irq_pc,
    input  logic               irq_in_slot,
    input  logic               rfe_valid,
    input  logic [4:0]         mfc_sel,
    output logic [31:0]        mfc_data,
    input  logic               mtc_valid,
    input  logic [4:0]         mtc_sel,
    input  logic [31:0]        mtc_data,
    output logic               flush,
    output logic [AW-1:0]      redirect_pc,
    output logic               sys_mode
);
    import trap_pkg::*;

    logic          sync_hit, irq_take, take;
    logic [4:0]    sync_code, t_code;
    logic [AW-1:0] sync_pc, t_pc, epc_q;
    logic          sync_slot, t_slot;
    logic [7:0]    t_pend;
    logic [31:0]   cause_q;

    trap_prio #(.NSRC(NSRC), .AW(AW), .RFE_SRC(RFE_SRC)) u_prio (
        .src_valid   (src_valid),
        .src_code    (src_code),
        .src_pc      (src_pc),
        .src_in_slot (src_in_slot),
        .rfe_fault   (rfe_valid && !sys_mode),
        .hit         (sync_hit),
        .win_code    (sync_code),
        .win_pc      (sync_pc),
        .win_slot    (sync_slot)
    );

    // Interrupts yield to synchronous faults and are masked in system mode.
    always_comb begin
        irq_take = !sync_hit && !sys_mode && (irq_code != 3'd0);
        take     = sync_hit || irq_take;
        t_code   = sync_hit ? sync_code : CODE_IRQ;
        t_pc     = sync_hit ? sync_pc : irq_pc;
        t_slot   = sync_hit ? sync_slot : irq_in_slot;
        t_pend   = sync_hit ? 8'd0 : irq_onehot(irq_code);
    end

    trap_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .code      (t_code),
        .pc        (t_pc),
        .slot      (t_slot),
        .pend      (t_pend),
        .rfe_ok    (rfe_valid && sys_mode && !sync_hit),
        .mtc_valid (mtc_valid),
        .mtc_sel   (mtc_sel),
        .mtc_data  (mtc_data),
        .mode_q    (sys_mode),
        .epc_q     (epc_q),
        .cause_q   (cause_q)
    );

    // Flush and redirect in the cycle the trap is accepted.
    always_comb begin
        flush       = take;
        redirect_pc = AW'(VECTOR);
    end

    // Combinational read port for the two registers.
    always_comb begin
        case (mfc_sel)
            SEL_CAUSE: mfc_data = cause_q;
            SEL_EPC:   mfc_data = 32'(epc_q);
            default:   mfc_data = 32'd0;
        endcase
    end

    a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_mode && !sync_hit) |-> !flush);
    a_r4_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit && irq_code != 3'd0) |=> (cause_q[15:8] == 8'd0));
endmodule

// File: tb/trap_ctrl_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a bench-side model of mode, saved PC and cause.
module trap_ctrl_tb;
    localparam int NSRC = 4;
    localparam int AW   = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSRC-1:0]    src_valid = '0;
    logic [NSRC*5-1:0]  src_code = '0;
    logic [NSRC*AW-1:0] src_pc = '0;
    logic [NSRC-1:0]    src_in_slot = '0;
    logic [2:0]         irq_code = '0;
    logic [AW-1:0]      irq_pc = '0;
    logic               irq_in_slot = 1'b0;
    logic               rfe_valid = 1'b0;
    logic [4:0]         mfc_sel = '0;
    logic [31:0]        mfc_data;
    logic               mtc_valid = 1'b0;
    logic [4:0]         mtc_sel = '0;
    logic [31:0]        mtc_data = '0;
    logic               flush;
    logic [AW-1:0]      redirect_pc;
    logic               sys_mode;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model state
    bit          m_mode = 1'b0;
    logic [31:0] m_epc = '0;
    logic [31:0] m_cause = '0;

    always #10 clk = ~clk;

    trap_ctrl #(.NSRC(NSRC), .AW(AW)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cause_of(input bit slot, input logic [2:0] irq,
                                             input logic [4:0] code);
        logic [31:0] c;
        c = {27'd0, code} << 2;
        if (irq != 3'd0) c = c | (32'd1 << (8 + irq));
        if (slot) c = c | 32'h8000_0000;
        return c;
    endfunction

    function automatic logic [31:0] read_of(input logic [4:0] sel);
        if (sel == 5'd13) return m_cause;
        if (sel == 5'd14) return m_epc;
        return 32'd0;
    endfunction

    task automatic idle(input logic [4:0] sel);
        src_valid = '0; irq_code = '0; rfe_valid = 1'b0; mtc_valid = 1'b0;
        irq_in_slot = 1'b0; src_in_slot = '0; mfc_sel = sel;
    endtask

    // Check this cycle against the model, then advance the model past the edge.
    task automatic step();
        bit sync, irq, t_slot, nxt_mode;
        logic [4:0]  code;
        logic [31:0] pc, n_epc, n_cause;
        int w;
        #2;
        sync = 0; w = 0;
        for (int i = 0; i < NSRC; i++)
            if (src_valid[i] || (i == 1 && rfe_valid && !m_mode)) begin sync = 1; w = i; end
        irq = !sync && !m_mode && irq_code != 3'd0;
        chk(flush == (sync || irq), "R2 flush", 32'(flush), 32'(sync || irq));
        if (flush) chk(redirect_pc == 32'h1000, "R2 redirect", redirect_pc, 32'h1000);
        chk(sys_mode == m_mode, "R2 mode", 32'(sys_mode), 32'(m_mode));
        chk(mfc_data == read_of(mfc_sel), "R9 read", mfc_data, read_of(mfc_sel));
        nxt_mode = m_mode; n_epc = m_epc; n_cause = m_cause;
        if (sync) begin
            code   = src_valid[w] ? src_code[w*5 +: 5] : 5'd10;
            pc     = src_pc[w*AW +: AW];
            t_slot = src_in_slot[w];
            n_epc  = t_slot ? pc - 4 : pc;
            n_cause = cause_of(t_slot, 3'd0, code);
            nxt_mode = 1;
        end else if (irq) begin
            n_epc = irq_in_slot ? irq_pc - 4 : irq_pc;
            n_cause = cause_of(irq_in_slot, irq_code, 5'd0);
            nxt_mode = 1;
        end else if (rfe_valid && m_mode) begin
            nxt_mode = 0;
        end
        @(posedge clk);
        #1;
        m_mode = nxt_mode; m_epc = n_epc; m_cause = n_cause;
    endtask

    // Idle cycle that reads one register and compares it to a fixed value.
    task automatic expect_reg(input logic [4:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        idle(sel);
        #1;
        chk(mfc_data == exp, tag, mfc_data, exp);
        step();
    endtask

    initial begin
        int seed;
        logic [4:0] codes [5];
        codes[0] = 5'd4; codes[1] = 5'd5; codes[2] = 5'd8; codes[3] = 5'd10; codes[4] = 5'd12;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(sys_mode == 1'b0, "R1 mode", 32'(sys_mode), 0);
        chk(flush == 1'b0, "R1 flush", 32'(flush), 0);
        expect_reg(5'd13, 32'd0, "R1 cause");
        expect_reg(5'd14, 32'd0, "R1 epc");

        // R6/R7/R8: interrupt code 4 on a delay-slot instruction in user mode
        @(negedge clk); idle(5'd0);
        irq_code = 3'd4; irq_pc = 32'h200; irq_in_slot = 1'b1;
        #1; chk(flush && redirect_pc == 32'h1000, "R2 irq redirect", redirect_pc, 32'h1000);
        step();
        chk(sys_mode == 1'b1, "R2 enter sys", 32'(sys_mode), 1);
        expect_reg(5'd13, 32'h8000_1000, "R6 R7 R5 cause irq4 slot");
        expect_reg(5'd14, 32'h1FC, "R8 epc slot");

        // R3: interrupt masked in system mode
        @(negedge clk); idle(5'd14); irq_code = 3'd3; irq_pc = 32'h300;
        #1; chk(!flush, "R3 irq masked", 32'(flush), 0);
        step();
        expect_reg(5'd14, 32'h1FC, "R3 epc kept");

        // R3: synchronous fault in system mode still traps and stays in system
        @(negedge clk); idle(5'd0);
        src_valid[2] = 1'b1; src_code[10 +: 5] = 5'd12; src_pc[64 +: 32] = 32'h1010;
        #1; chk(flush, "R3 sync in sys", 32'(flush), 1);
        step();
        chk(sys_mode, "R3 stays sys", 32'(sys_mode), 1);
        expect_reg(5'd13, 32'h30, "R5 overflow code");
        expect_reg(5'd14, 32'h1010, "R8 epc no slot");

        // R10: return in system mode goes to user
        @(negedge clk); idle(5'd0); rfe_valid = 1'b1;
        #1; chk(!flush, "R10 rfe sys no flush", 32'(flush), 0);
        step();
        chk(!sys_mode, "R10 back to user", 32'(sys_mode), 0);

        // R10: return in user mode traps as illegal instruction
        @(negedge clk); idle(5'd0); rfe_valid = 1'b1; src_pc[32 +: 32] = 32'h44;
        #1; chk(flush, "R10 rfe user traps", 32'(flush), 1);
        step();
        expect_reg(5'd13, 32'h28, "R10 code 10");
        expect_reg(5'd14, 32'h44, "R10 epc");
        @(negedge clk); idle(5'd0); rfe_valid = 1'b1; step();

        // R4: oldest source wins over younger source and interrupt
        @(negedge clk); idle(5'd0);
        src_valid = 4'b1001; src_code[0 +: 5] = 5'd4; src_pc[0 +: 32] = 32'h8;
        src_code[15 +: 5] = 5'd5; src_pc[96 +: 32] = 32'h20; irq_code = 3'd2;
        step();
        expect_reg(5'd13, 32'h14, "R4 oldest code");
        expect_reg(5'd14, 32'h20, "R4 oldest epc");

        // R9: unmapped read and ignored write
        expect_reg(5'd7, 32'd0, "R9 unmapped");
        @(negedge clk); idle(5'd13); mtc_valid = 1'b1; mtc_sel = 5'd13; mtc_data = 32'hFFFF_FFFF;
        step();
        @(negedge clk); idle(5'd14); mtc_valid = 1'b1; mtc_sel = 5'd14; mtc_data = 32'h1234;
        step();
        expect_reg(5'd13, 32'h14, "R9 cause write ignored");
        expect_reg(5'd14, 32'h20, "R9 epc write ignored");
        @(negedge clk); idle(5'd0); rfe_valid = 1'b1; step();

        // Random traffic against the model (R2..R10)
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            idle(5'(12 + ($urandom % 4)));
            for (int i = 0; i < NSRC; i++) begin
                src_valid[i]         = ($urandom % 12) == 0;
                src_code[i*5 +: 5]   = codes[$urandom % 5];
                src_pc[i*AW +: AW]   = {$urandom, 2'b00} + 32'h10;
                src_in_slot[i]       = $urandom % 2;
            end
            rfe_valid   = !src_valid[1] && ($urandom % 8) == 0;
            irq_code    = (($urandom % 5) == 0) ? 3'($urandom) : 3'd0;
            irq_pc      = {$urandom, 2'b00} + 32'h10;
            irq_in_slot = $urandom % 2;
            mtc_valid   = $urandom % 2;
            mtc_sel     = 5'(13 + ($urandom % 2));
            mtc_data    = $urandom;
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule